// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps one table of n-bit saturating counters. Each entry is selected by the low-order bits of the branch address joined with a register that records the outcomes of the last m resolved conditional branches. As a result, every branch owns 2^m separate counters, and which one it uses depends on how the most recent branches went. That lets the block learn patterns where one branch's direction follows from its neighbours' directions, which a counter per branch alone cannot capture.

The fetch stage drives a branch address on the lookup port. In the same cycle it receives the predicted direction and a copy of the global history that was used to form the index. That copy travels down the pipeline with the branch. When the branch resolves, the resolve port gets the address, the real outcome and that copy. The block then moves the selected counter one step toward the outcome and shifts the outcome into the global history.

Both ports are valid-qualified streams that never apply back-pressure. A lookup with valid high is answered combinationally in the same cycle. A resolve with valid high is accepted on the next rising clock edge. For that reason neither port has a ready signal, and the sender may present a new beat every cycle.

Top module: `corr_bpred`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets every counter to 0 and the global history to 0, so every lookup after reset predicts not-taken and lk_hist reads 0.
- R2: Each accepted resolve shifts rs_taken into history bit 0 and moves every older bit up one place, dropping the oldest. Without rs_valid the history does not change.
- R3: The counter used by both ports is the entry at index {pc[PC_W-1:0], history}, with the address in the upper bits. The same address under different history values uses different counters.
- R4: lk_taken is 1 exactly when the selected counter is at least 2^(CTR_W-1). With CTR_W=2, the values 0 and 1 predict not-taken and the values 2 and 3 predict taken.
- R5: A taken resolve increments the selected counter but never past 2^CTR_W-1, so there is no wrap to 0.
- R6: A not-taken resolve decrements the selected counter but never below 0, so there is no wrap to the top value.
- R7: With CTR_W=2, a counter at either end needs two consecutive opposite outcomes before its prediction changes. Each resolve moves a counter by at most one step.
- R8: A resolve updates the entry chosen by rs_hist, which is the snapshot taken at prediction time. The current history register does not select the entry.
- R9: When a lookup and a resolve hit the same entry in one cycle, the lookup returns the value from before the update. The new value becomes visible from the next cycle.
- R10: lk_taken is 0 while lk_valid is low. Lookups change neither the counters nor the history.
- R11: With HIST_W=1 and CTR_W=1, two branches whose outcomes alternate together (both taken, then both not-taken) are predicted correctly from the second pass on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup beat present |
| lk_pc | input | PC_W | Low-order branch address bits for the lookup |
| lk_taken | output | 1 | Predicted direction, 1 means taken |
| lk_hist | output | HIST_W | History used for this lookup, to be carried with the branch |
| rs_valid | input | 1 | Resolve beat present, always accepted |
| rs_pc | input | PC_W | Low-order address bits of the resolved branch |
| rs_hist | input | HIST_W | History snapshot captured when the branch was predicted |
| rs_taken | input | 1 | Actual outcome, 1 means taken |

## Verification
The bench builds the default instance with two history bits, two-bit counters and four address bits. That gives 64 entries, four history contexts per branch and counters with both saturation ends and two-step hysteresis. With that instance the bench checks snapshot-versus-current-history indexing, both saturation ends and the same-cycle read-before-write case. A second instance uses one history bit, one-bit counters and two address bits. It makes the smallest correlating arrangement testable, where the previous outcome alone chooses between two single-bit predictors for each branch.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

  typedef enum logic {
    DIR_NOT = 1'b0,
    DIR_TKN = 1'b1
  } dir_e;

  function automatic dir_e dir_from_bit(input logic b);
    return b ? DIR_TKN : DIR_NOT;
  endfunction

endpackage

// File: rtl/cbp_history.sv
module cbp_history
  import cbp_pkg::*;
#(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  dir_e              shift_dir,
  output logic [HIST_W-1:0] hist
);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_nxt;

  generate
    if (HIST_W == 1) begin : g_single
      assign hist_nxt = shift_dir;
    end else begin : g_multi
      assign hist_nxt = {hist_q[HIST_W-2:0], shift_dir};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q <= hist_nxt;
    end
  end

  assign hist = hist_q;

  a_r1_hist_cleared: assert property (@(posedge clk) rst |=> hist == '0);

  a_r2_newest_bit: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> hist[0] == $past(shift_dir));

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist));

  generate
    if (HIST_W > 1) begin : g_age_chk
      a_r2_older_bits: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> hist[HIST_W-1:1] == $past(hist[HIST_W-2:0]));
    end
  endgenerate

endmodule

// File: rtl/cbp_index.sv
module cbp_index #(
  parameter int PC_W   = 4,
  parameter int HIST_W = 2,
  localparam int IDX_W = PC_W + HIST_W
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);

  assign idx = {pc, hist};

endmodule

// File: rtl/cbp_sat_step.sv
module cbp_sat_step
  import cbp_pkg::*;
#(
  parameter int W = 2
) (
  input  logic [W-1:0] cur,
  input  dir_e         dir,
  output logic [W-1:0] nxt
);

  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] BOT = '0;

  always_comb begin
    nxt = cur;
    if (dir == DIR_TKN) begin
      if (cur != TOP) nxt = cur + 1'b1;
    end else begin
      if (cur != BOT) nxt = cur - 1'b1;
    end
  end

endmodule

// File: rtl/cbp_ctr_table.sv
module cbp_ctr_table
  import cbp_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int CTR_W = 2,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_val,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  dir_e             wr_dir
);

  localparam logic [CTR_W-1:0] TOP = '1;

  logic [CTR_W-1:0] ctr_q [DEPTH];
  logic [CTR_W-1:0] wr_old;
  logic [CTR_W-1:0] wr_new;

  assign rd_val = ctr_q[rd_idx];
  assign wr_old = ctr_q[wr_idx];

  cbp_sat_step #(.W(CTR_W)) step_i (
    .cur (wr_old),
    .dir (wr_dir),
    .nxt (wr_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= '0;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= wr_new;
    end
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_dir == DIR_TKN && wr_old == TOP |=> ctr_q[$past(wr_idx)] == TOP);

  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_dir == DIR_NOT && wr_old == '0 |=> ctr_q[$past(wr_idx)] == '0);

  a_r7_single_step: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ctr_q[$past(wr_idx)] == $past(wr_old)) ||
              (ctr_q[$past(wr_idx)] == $past(wr_old) + 1'b1) ||
              (ctr_q[$past(wr_idx)] == $past(wr_old) - 1'b1));

endmodule

// File: rtl/corr_bpred.sv
module corr_bpred
  import cbp_pkg::*;
#(
  parameter int HIST_W = 2,
  parameter int CTR_W  = 2,
  parameter int PC_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_taken,
  output logic [HIST_W-1:0] lk_hist,
  input  logic              rs_valid,
  input  logic [PC_W-1:0]   rs_pc,
  input  logic [HIST_W-1:0] rs_hist,
  input  logic              rs_taken
);

  localparam int IDX_W = PC_W + HIST_W;

  logic [HIST_W-1:0] ghist;
  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  rs_idx;
  logic [CTR_W-1:0]  lk_ctr;
  dir_e              rs_dir;
  dir_e              lk_dir;

  assign rs_dir = dir_from_bit(rs_taken);

  cbp_history #(.HIST_W(HIST_W)) hist_i (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (rs_valid),
    .shift_dir (rs_dir),
    .hist      (ghist)
  );

  cbp_index #(.PC_W(PC_W), .HIST_W(HIST_W)) lk_idx_i (
    .pc   (lk_pc),
    .hist (ghist),
    .idx  (lk_idx)
  );

  cbp_index #(.PC_W(PC_W), .HIST_W(HIST_W)) rs_idx_i (
    .pc   (rs_pc),
    .hist (rs_hist),
    .idx  (rs_idx)
  );

  cbp_ctr_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) tbl_i (
    .clk    (clk),
    .rst    (rst),
    .rd_idx (lk_idx),
    .rd_val (lk_ctr),
    .wr_en  (rs_valid),
    .wr_idx (rs_idx),
    .wr_dir (rs_dir)
  );

  assign lk_dir   = dir_from_bit(lk_ctr[CTR_W-1]);
  assign lk_taken = lk_valid && (lk_dir == DIR_TKN);
  assign lk_hist  = ghist;

  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> !lk_taken);

  a_r10_lookup_no_state: assert property (@(posedge clk) disable iff (rst)
    !rs_valid |=> $stable(lk_hist));

endmodule

// File: tb/corr_bpred_tb_top.sv
module corr_bpred_tb_top;
  localparam int CLK_NS = 10;
  localparam int HW = 2;
  localparam int CW = 2;
  localparam int PW = 4;
  localparam int NENT = 1 << (PW + HW);
  localparam int CMAX = (1 << CW) - 1;
  localparam int CHALF = 1 << (CW - 1);

  logic clk = 1'b0;
  logic rst;
  always #(CLK_NS / 2) clk = ~clk;

  logic          lk_valid, lk_taken, rs_valid, rs_taken;
  logic [PW-1:0] lk_pc, rs_pc;
  logic [HW-1:0] lk_hist, rs_hist;

  logic       b_lk_valid, b_lk_taken, b_rs_valid, b_rs_taken;
  logic [1:0] b_lk_pc, b_rs_pc;
  logic [0:0] b_lk_hist, b_rs_hist;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int mdl_ctr[NENT];
  int mdl_hist = 0;

  corr_bpred #(.HIST_W(HW), .CTR_W(CW), .PC_W(PW)) dut_i (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_hist(lk_hist),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_hist(rs_hist), .rs_taken(rs_taken)
  );

  corr_bpred #(.HIST_W(1), .CTR_W(1), .PC_W(2)) dut_11 (
    .clk(clk), .rst(rst),
    .lk_valid(b_lk_valid), .lk_pc(b_lk_pc), .lk_taken(b_lk_taken), .lk_hist(b_lk_hist),
    .rs_valid(b_rs_valid), .rs_pc(b_rs_pc), .rs_hist(b_rs_hist), .rs_taken(b_rs_taken)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_pred(input int pc);
    return (mdl_ctr[pc * (1 << HW) + mdl_hist] >= CHALF) ? 1 : 0;
  endfunction

  task automatic mdl_update(input int pc, input int h, input bit t);
    int ix;
    ix = pc * (1 << HW) + h;
    if (t && mdl_ctr[ix] < CMAX) mdl_ctr[ix]++;
    if (!t && mdl_ctr[ix] > 0) mdl_ctr[ix]--;
    mdl_hist = ((mdl_hist << 1) | int'(t)) & ((1 << HW) - 1);
  endtask

  task automatic resolve(input int pc, input int h, input bit t);
    @(negedge clk);
    rs_valid = 1'b1; rs_pc = PW'(pc); rs_hist = HW'(h); rs_taken = t;
    @(posedge clk); #1;
    rs_valid = 1'b0;
    mdl_update(pc, h, t);
  endtask

  task automatic look(input int pc, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = PW'(pc);
    #1;
    check(req, int'(lk_taken), exp_pred(pc));
    check(req, int'(lk_hist), mdl_hist);
    lk_valid = 1'b0;
  endtask

  task automatic set_hist(input int h);
    resolve(15, mdl_hist, bit'((h >> 1) & 1));
    resolve(15, mdl_hist, bit'(h & 1));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NENT; i++) mdl_ctr[i] = 0;
    mdl_hist = 0;
  endtask

  // R1: after reset every lookup predicts not-taken, history reads 0
  task automatic t_reset();
    do_reset();
    look(0, "R1 reset pc0");
    look(7, "R1 reset pc7");
    look(14, "R1 reset pc14");
  endtask

  // R2: history shift order and hold while idle
  task automatic t_history();
    resolve(2, mdl_hist, 1'b1);
    look(2, "R2 after T");
    resolve(2, mdl_hist, 1'b0);
    look(2, "R2 after T,N");
    resolve(2, mdl_hist, 1'b1);
    look(2, "R2 after T,N,T");
    repeat (3) @(negedge clk);
    look(2, "R2 idle hold");
  endtask

  // R4 R5 R6 R7: saturation and hysteresis on pc3, context 0
  task automatic t_saturate();
    for (int i = 0; i < 5; i++) resolve(3, 0, 1'b1);
    set_hist(0);
    look(3, "R5 top saturates, no wrap");
    resolve(3, 0, 1'b0);
    set_hist(0);
    look(3, "R7 one miss keeps taken");
    resolve(3, 0, 1'b0);
    set_hist(0);
    look(3, "R7 second miss flips");
    for (int i = 0; i < 5; i++) resolve(3, 0, 1'b0);
    set_hist(0);
    look(3, "R6 bottom saturates, no wrap");
    resolve(3, 0, 1'b1);
    set_hist(0);
    look(3, "R4 value 1 predicts not-taken");
    resolve(3, 0, 1'b1);
    set_hist(0);
    look(3, "R4 value 2 predicts taken");
  endtask

  // R3: same address, different history context
  task automatic t_index();
    resolve(5, 1, 1'b1);
    resolve(5, 1, 1'b1);
    set_hist(0);
    look(5, "R3 context 00 untouched");
    set_hist(1);
    look(5, "R3 context 01 trained");
    set_hist(1);
    look(4, "R3 neighbour address untouched");
  endtask

  // R8: snapshot selects the entry, not the live history
  task automatic t_snapshot();
    set_hist(3);
    resolve(7, 2, 1'b1);
    resolve(7, 2, 1'b1);
    set_hist(3);
    look(7, "R8 live-history entry untouched");
    set_hist(2);
    look(7, "R8 snapshot entry trained");
  endtask

  // R9: read before write on the same entry
  task automatic t_same_cycle();
    resolve(9, 0, 1'b1);
    set_hist(0);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = PW'(9);
    rs_valid = 1'b1; rs_pc = PW'(9); rs_hist = '0; rs_taken = 1'b1;
    #1;
    check("R9 old value on collision", int'(lk_taken), 0);
    @(posedge clk); #1;
    lk_valid = 1'b0; rs_valid = 1'b0;
    mdl_update(9, 0, 1'b1);
    set_hist(0);
    look(9, "R9 new value next cycle");
  endtask

  // R10: invalid lookups give no prediction and change nothing
  task automatic t_idle_lookup();
    set_hist(0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      lk_valid = 1'b0; lk_pc = PW'(3);
      #1;
      check("R10 no prediction without valid", int'(lk_taken), 0);
    end
    look(3, "R10 state unchanged by lookups");
  endtask

  // R11: one-bit history, one-bit counters, correlated pair
  task automatic t_pair();
    for (int rnd = 0; rnd < 4; rnd++) begin
      for (int s = 0; s < 4; s++) begin
        bit actual;
        actual = (s < 2);
        @(negedge clk);
        b_lk_valid = 1'b1; b_lk_pc = 2'(s % 2);
        #1;
        if (rnd >= 1) check("R11 correlated pair", int'(b_lk_taken), int'(actual));
        b_rs_valid = 1'b1; b_rs_pc = 2'(s % 2); b_rs_hist = b_lk_hist; b_rs_taken = actual;
        @(posedge clk); #1;
        b_lk_valid = 1'b0; b_rs_valid = 1'b0;
      end
    end
  endtask

  // R1: reset after training clears everything again
  task automatic t_rereset();
    do_reset();
    look(3, "R1 re-reset pc3");
    look(9, "R1 re-reset pc9");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    rst = 1'b1;
    lk_valid = 1'b0; lk_pc = '0;
    rs_valid = 1'b0; rs_pc = '0; rs_hist = '0; rs_taken = 1'b0;
    b_lk_valid = 1'b0; b_lk_pc = '0;
    b_rs_valid = 1'b0; b_rs_pc = '0; b_rs_hist = '0; b_rs_taken = 1'b0;
    for (int i = 0; i < NENT; i++) mdl_ctr[i] = 0;
    t_reset();
    t_history();
    t_saturate();
    t_index();
    t_snapshot();
    t_same_cycle();
    t_idle_lookup();
    t_pair();
    t_rereset();
    done = 1'b1;
    summary();
  end

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL all requirements: watchdog, actual running expected finished");
      summary();
    end
  end

endmodule